// File: doc/BRIEF.md
# Probabilistic Forward Confidence Counter Bank

This block holds a bank of 3-bit confidence counters, one for each entry of a value predictor. A predicted value is trusted only when its counter is at the top level, 7. A wrong outcome clears the counter. A right outcome moves it up one level only when a pseudo-random draw succeeds. The chance of success depends on the current level and on a mode input. The result is that a 3-bit counter needs as many right outcomes in a row as a much wider counter would.

The predictor reports each outcome as one update: a valid strobe, an entry index and a correct/incorrect flag. An independent read port returns the level and the trusted flag for any entry.

The mode input picks one of two probability sets. The squash mode suits a core that recovers by flushing the pipeline, so steps above level 1 are rare. The replay mode suits a core that recovers by re-executing only the affected instructions, so steps above level 1 come twice as often.

The random source is a 16-bit LFSR. It moves forward once for every update, so a given update sequence always produces the same counter values.

Top module: `fpc_conf_bank`

## Requirements
- R1: While reset is active and just after it ends, every counter reads 0 and the trusted flag is low.
- R2: An update with the incorrect flag (`upd_correct_i`=0) sets that counter to 0, whatever its level and whatever the mode.
- R3: A correct update to a counter at level 0 always sets it to level 1.
- R4: With `mode_i`=0 (squash), a correct update to a counter at level 1 to 6 adds one only when bits [3:0] of the LFSR state in the update cycle are all zero. Otherwise the counter holds its level.
- R5: With `mode_i`=1 (replay), a correct update to a counter at level 1 to 6 adds one only when bits [2:0] of the LFSR state in the update cycle are all zero. Otherwise the counter holds its level.
- R6: A correct update to a counter at level 7 leaves it at 7.
- R7: `rd_conf_o` is high exactly when the counter selected by `rd_idx_i` is at 7.
- R8: The LFSR loads 16'hACE1 on reset. On each cycle with `upd_valid_i` high it shifts left by one bit, taking `s[15]^s[13]^s[12]^s[10]` into bit 0. Otherwise it holds its state.
- R9: The read port shows the stored level combinationally. A read in the same cycle as an update to the same index returns the level before the update. Updates leave every other index unchanged.
- R10: While `upd_valid_i` is low, no counter changes and the LFSR does not advance, whatever the other update inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| upd_valid_i | input | 1 | Outcome update strobe |
| upd_idx_i | input | IDX_W | Entry to update |
| upd_correct_i | input | 1 | 1 = prediction was right, 0 = wrong |
| mode_i | input | 1 | 0 = squash probabilities, 1 = replay probabilities |
| rd_idx_i | input | IDX_W | Entry to read |
| rd_level_o | output | 3 | Current level of the read entry |
| rd_conf_o | output | 1 | Read entry is saturated (trusted) |

## Verification
The assertions assume that the index inputs are always known, that only one update arrives per cycle, and that every input holds steady across each rising edge. They also assume that the read index and the update index are the same in the cycle when a step is checked.

The bench changes inputs only at falling edges, with one read-index change in the middle of each cycle, and makes at most one update per cycle. It reads back every updated entry after the edge. Most stimulus uses four entries so that runs of repeated updates occur. Long runs of correct updates on single entries push counters to saturation in both modes.

// File: rtl/fpc_conf_pkg.sv
package fpc_conf_pkg;
  localparam int unsigned LVL_W    = 3;
  localparam int unsigned LFSR_W   = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
  localparam int unsigned K_SQUASH = 4;  // success when low 4 bits are zero: 1/16
  localparam int unsigned K_REPLAY = 3;  // 1/8

  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_MAX = lvl_t'((1 << LVL_W) - 1);

  typedef enum logic {
    MODE_SQUASH = 1'b0,
    MODE_REPLAY = 1'b1
  } mode_e;

  function automatic logic [LFSR_W-1:0] low_mask(input int unsigned k);
    logic [LFSR_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(LFSR_W); i++) m[i] = (i < int'(k));
    return m;
  endfunction
endpackage

// File: rtl/fpc_prng.sv
module fpc_prng
  import fpc_conf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] state_q;
  logic              fb;

  assign fb = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= LFSR_SEED;
    else if (adv_i) state_q <= {state_q[LFSR_W-2:0], fb};
  end

  assign state_o = state_q;
endmodule

// File: rtl/fpc_step.sv
module fpc_step
  import fpc_conf_pkg::*;
(
  input  lvl_t              lvl_i,
  input  logic              correct_i,
  input  logic              mode_i,
  input  logic [LFSR_W-1:0] rnd_i,
  output lvl_t              lvl_o
);
  localparam logic [LFSR_W-1:0] MASK_SQ = low_mask(K_SQUASH);
  localparam logic [LFSR_W-1:0] MASK_RP = low_mask(K_REPLAY);

  logic [LFSR_W-1:0] mask;
  logic              draw_ok;

  assign mask    = (mode_e'(mode_i) == MODE_REPLAY) ? MASK_RP : MASK_SQ;
  assign draw_ok = ((rnd_i & mask) == '0);

  always_comb begin
    if (!correct_i)            lvl_o = '0;
    else if (lvl_i == '0)      lvl_o = lvl_t'(1);
    else if (lvl_i == LVL_MAX) lvl_o = LVL_MAX;
    else if (draw_ok)          lvl_o = lvl_i + lvl_t'(1);
    else                       lvl_o = lvl_i;
  end
endmodule

// File: rtl/fpc_store.sv
module fpc_store
  import fpc_conf_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  lvl_t             wr_lvl_i,
  input  logic [IDX_W-1:0] ra_idx_i,
  output lvl_t             ra_lvl_o,
  input  logic [IDX_W-1:0] rb_idx_i,
  output lvl_t             rb_lvl_o
);
  lvl_t mem [ENTRIES];

  for (genvar g = 0; g < int'(ENTRIES); g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    mem[g] <= '0;
      else if (we_i && wr_idx_i == IDX_W'(g))         mem[g] <= wr_lvl_i;
    end
  end

  assign ra_lvl_o = mem[ra_idx_i];
  assign rb_lvl_o = mem[rb_idx_i];
endmodule

// File: rtl/fpc_conf_bank.sv
module fpc_conf_bank
  import fpc_conf_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_valid_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_correct_i,
  input  logic             mode_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [LVL_W-1:0] rd_level_o,
  output logic             rd_conf_o
);
  logic [LFSR_W-1:0] lfsr_w;
  lvl_t              cur_lvl;
  lvl_t              nxt_lvl;
  lvl_t              rd_lvl;

  fpc_prng u_prng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (upd_valid_i),
    .state_o(lfsr_w)
  );

  fpc_step u_step (
    .lvl_i    (cur_lvl),
    .correct_i(upd_correct_i),
    .mode_i   (mode_i),
    .rnd_i    (lfsr_w),
    .lvl_o    (nxt_lvl)
  );

  fpc_store #(.ENTRIES(ENTRIES)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (upd_valid_i),
    .wr_idx_i(upd_idx_i),
    .wr_lvl_i(nxt_lvl),
    .ra_idx_i(upd_idx_i),
    .ra_lvl_o(cur_lvl),
    .rb_idx_i(rd_idx_i),
    .rb_lvl_o(rd_lvl)
  );

  assign rd_level_o = rd_lvl;
  assign rd_conf_o  = (rd_lvl == LVL_MAX);
endmodule

// File: rtl/fpc_conf_bank_chk.sv
module fpc_conf_bank_chk #(
  parameter int unsigned IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             upd_valid_i,
  input logic [IDX_W-1:0] upd_idx_i,
  input logic             upd_correct_i,
  input logic [IDX_W-1:0] rd_idx_i,
  input logic [2:0]       rd_level_o,
  input logic             rd_conf_o,
  input logic [15:0]      lfsr_w
);
  // R2
  miss_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_correct_i) |=> (rd_idx_i != $past(upd_idx_i)) || (rd_level_o == 3'd0));

  // R3
  first_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_correct_i && rd_idx_i == upd_idx_i && rd_level_o == 3'd0)
    |=> (rd_idx_i != $past(upd_idx_i)) || (rd_level_o == 3'd1));

  // R4 R5
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_correct_i && rd_idx_i == upd_idx_i)
    |=> (rd_idx_i != $past(upd_idx_i)) || (rd_level_o == $past(rd_level_o))
        || (rd_level_o == $past(rd_level_o) + 3'd1));

  // R6
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_correct_i && rd_idx_i == upd_idx_i && rd_level_o == 3'd7)
    |=> (rd_idx_i != $past(upd_idx_i)) || (rd_level_o == 3'd7));

  // R7
  conf_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rd_conf_o) && $stable(rd_idx_i))
    |-> $past(upd_valid_i && upd_correct_i && upd_idx_i == rd_idx_i));

  // R8
  lfsr_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_w != 16'd0);

  // R8
  lfsr_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> lfsr_w != $past(lfsr_w));

  // R10
  lfsr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(lfsr_w));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> ($past(rd_idx_i) != rd_idx_i) || $stable(rd_level_o));
endmodule

bind fpc_conf_bank fpc_conf_bank_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .upd_valid_i  (upd_valid_i),
  .upd_idx_i    (upd_idx_i),
  .upd_correct_i(upd_correct_i),
  .rd_idx_i     (rd_idx_i),
  .rd_level_o   (rd_level_o),
  .rd_conf_o    (rd_conf_o),
  .lfsr_w       (lfsr_w)
);

// File: tb/fpc_conf_bank_tb.sv
module fpc_conf_bank_tb;
  localparam int ENTRIES = 16;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int CLK_NS  = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             upd_valid_i = 1'b0;
  logic [IDX_W-1:0] upd_idx_i = '0;
  logic             upd_correct_i = 1'b0;
  logic             mode_i = 1'b0;
  logic [IDX_W-1:0] rd_idx_i = '0;
  logic [2:0]       rd_level_o;
  logic             rd_conf_o;

  int total = 0;
  int bad   = 0;
  bit over  = 0;

  int          model [ENTRIES];
  logic [15:0] lfsr_m;

  always #(CLK_NS/2) clk_i = ~clk_i;

  fpc_conf_bank #(.ENTRIES(ENTRIES)) u_dut (.*);

  task automatic chk(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic op(input bit v, input int idx, input bit ok, input bit md, input int ridx);
    int    cur, nxt, k;
    string tag;
    @(negedge clk_i);
    upd_valid_i = v; upd_idx_i = IDX_W'(idx); upd_correct_i = ok;
    mode_i = md; rd_idx_i = IDX_W'(ridx);
    #1;
    chk(rd_level_o, model[ridx], "R9");           // pre-update view
    chk(rd_conf_o, int'(model[ridx] == 7), "R7");
    cur = model[idx];
    nxt = cur;
    tag = "R10";
    if (v) begin
      k = md ? 3 : 4;
      if (!ok)                               begin nxt = 0; tag = "R2"; end
      else if (cur == 0)                     begin nxt = 1; tag = "R3"; end
      else if (cur == 7)                     begin nxt = 7; tag = "R6"; end
      else begin
        tag = md ? "R5" : "R4";
        if ((lfsr_m & 16'((1 << k) - 1)) == 0) nxt = cur + 1;
      end
      model[idx] = nxt;
      lfsr_m = lfsr_next(lfsr_m);
    end
    @(posedge clk_i);
    #2;
    rd_idx_i = IDX_W'(idx);
    #1;
    chk(rd_level_o, nxt, tag);
    chk(rd_conf_o, int'(nxt == 7), "R7");
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < ENTRIES; i++) begin
      rd_idx_i = IDX_W'(i);
      #1;
      chk(rd_level_o, model[i], req);
      chk(rd_conf_o, int'(model[i] == 7), req);
    end
  endtask

  initial begin
    for (int i = 0; i < ENTRIES; i++) model[i] = 0;
    lfsr_m = 16'hACE1;
    repeat (3) @(posedge clk_i);
    #1;
    sweep("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    sweep("R1");

    // directed first step and clear
    op(1, 2, 1, 0, 2);
    op(1, 2, 0, 0, 3);
    op(1, 2, 1, 1, 2);

    // saturate in replay mode, then hold at 7
    for (int n = 0; n < 300; n++) op(1, 5, 1, 1, (n % 2) ? 5 : 9);
    chk(int'(model[5] == 7), 1, "R5");
    // saturate in squash mode
    for (int n = 0; n < 600; n++) op(1, 6, 1, 0, 6);
    chk(int'(model[6] == 7), 1, "R4");
    op(1, 6, 1, 1, 6);
    op(1, 6, 0, 1, 6);

    // mixed traffic on a few entries
    for (int n = 0; n < 3000; n++) begin
      int idx;
      idx = $urandom_range(0, 3);
      op(1, idx, ($urandom_range(0, 19) != 0), $urandom_range(0, 1), $urandom_range(0, ENTRIES - 1));
    end

    // idle: update inputs toggle with strobe low
    for (int n = 0; n < 60; n++)
      op(0, $urandom_range(0, ENTRIES - 1), $urandom_range(0, 1), $urandom_range(0, 1),
         $urandom_range(0, ENTRIES - 1));
    sweep("R10");
    // LFSR must not have moved while idle: next draws still follow the model
    for (int n = 0; n < 200; n++) op(1, 1, 1, 1, 1);
    sweep("R8");

    if (!over) begin
      over = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 200000);
    if (!over) begin
      over = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule